// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects level-sensitive interrupt requests from a parameterized set of peripheral sources and forwards at most one of them to the CPU. Each source has a pending flag. The flag is set whenever the source's request input is high. It stays set until software clears it. Each source also has a 4-bit priority level held in software-writable priority words. On every peripheral clock cycle the block picks the pending source with the highest nonzero level. Ties go to the lowest-numbered source. The block then compares that level against the CPU's 4-bit mask and raises the CPU request only when the level is strictly greater than the mask.

The winner's level and an event code are presented on registered outputs alongside the request line. The event code is a base value plus the source index times a fixed step. When the CPU acknowledges the request, the current event code is latched into an event register that software reads over the register bus. Software services a source by writing a one to its bit in the flag register. Losing sources remain pending and win in later cycles.

The register bus is a single-cycle write port with a registered read of the addressed word:

- Priority words sit at addresses 0 to NPRW-1.
- The flag register sits at NPRW.
- The event register sits at NPRW+1.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among sources whose pending flag is set and whose level is nonzero, the one with the highest level wins, and its level appears on `irq_lvl`. Outputs are registered, so they reflect a request two rising edges after the request input is sampled high.
- R2: A pending flag remains set after its request input returns low, until software clears it. A source that lost arbitration wins once the winner is cleared.
- R3: When several pending sources share the highest level, the source with the lowest index wins.
- R4: A source with level 0 never wins. If only level-0 sources are pending, `irq_out` is 0, `irq_lvl` is 0 and `irq_code` is 0.
- R5: `irq_out` is 1 only when the winning level is strictly greater than `cpu_mask`; an equal or lower level gives 0.
- R6: After a synchronous reset, `irq_out`, `irq_lvl`, `irq_code`, all priority words, all pending flags and the event register are 0.
- R7: `irq_code` of the winner equals CODE_BASE + index * CODE_STEP (defaults 0x0200 and 0x0020).
- R8: A cycle with `cpu_ack` high while `irq_out` is high copies `irq_code` into the event register, readable at address NPRW+1. An acknowledge while `irq_out` is low leaves the event register unchanged.
- R9: A bus write to the flag register (address NPRW) clears each pending flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Reading the flag register returns the pending flags in bits NSRC-1:0.
- R10: Source i's level is bits [4*(i%8)+3 : 4*(i%8)] of priority word i/8. Priority words read back exactly as written, one cycle after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Level-sensitive request per source |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| cpu_ack | input | 1 | CPU acknowledge of the forwarded request |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data of `bus_addr` |
| irq_out | output | 1 | Request toward the CPU |
| irq_lvl | output | 4 | Level of the current winner |
| irq_code | output | CODE_W | Event code of the current winner |

## Verification
The hardest situation to reach from the ports is a losing source that is still pending after every request line has gone low. It is reached only through the sticky flags and a selective clear of the winner. The bench pulses two requests with different levels and drops both lines. It clears only the winner's flag and then expects the other source to take over, with the flag register showing just that source. Equal-level ties, level-0 sources and masks equal to the winning level are set up directly. Random trials then combine priority writes, request patterns and masks, with a clear of all flags between trials.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W  = 4;
  localparam int DATA_W = 32;
  localparam int PER_W  = DATA_W / LVL_W;

  function automatic int words_for(input int nsrc);
    return (nsrc + PER_W - 1) / PER_W;
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NSRC   = 12,
  parameter int ADDR_W = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [words_for(NSRC)-1:0][DATA_W-1:0] words,
  output logic [NSRC-1:0][LVL_W-1:0]         levels
);
  localparam int NPRW = words_for(NSRC);

  logic [NPRW-1:0][DATA_W-1:0] word_q;

  for (genvar w = 0; w < NPRW; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[w] <= '0;
      else if (we && addr == ADDR_W'(w))
        word_q[w] <= wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign levels[i] = word_q[i / PER_W][(i % PER_W) * LVL_W +: LVL_W];
  end

  assign words = word_q;
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst)
      pend <= '0;
    else
      pend <= (pend | req) & ~clr;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 12,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVL_W-1:0] levels,
  output logic                       found,
  output logic [IDX_W-1:0]           win_idx,
  output logic [LVL_W-1:0]           win_lvl
);
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && levels[i] > win_lvl) begin
        win_lvl = levels[i];
        win_idx = IDX_W'(i);
      end
    end
    found = (win_lvl != '0);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int               NSRC      = 12,
  parameter int               ADDR_W    = 3,
  parameter int               CODE_W    = 16,
  parameter logic [CODE_W-1:0] CODE_BASE = 16'h0200,
  parameter logic [CODE_W-1:0] CODE_STEP = 16'h0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_req,
  input  logic [3:0]        cpu_mask,
  input  logic              cpu_ack,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic [3:0]        irq_lvl,
  output logic [CODE_W-1:0] irq_code
);
  localparam int NPRW      = words_for(NSRC);
  localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int FLAG_ADDR = NPRW;
  localparam int EVT_ADDR  = NPRW + 1;

  logic [NPRW-1:0][DATA_W-1:0] words;
  logic [NSRC-1:0][LVL_W-1:0]  levels;
  logic [NSRC-1:0]             pend_q;
  logic [NSRC-1:0]             clr_vec;
  logic                        found;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic [CODE_W-1:0]           evt_q;
  logic [CODE_W-1:0]           code_next;
  logic [DATA_W-1:0]           rd_next;

  assign clr_vec = (bus_we && bus_addr == ADDR_W'(FLAG_ADDR)) ? bus_wdata[NSRC-1:0] : '0;

  irq_prio_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .words(words), .levels(levels)
  );

  irq_pend_flags #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req(src_req), .clr(clr_vec), .pend(pend_q)
  );

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .pend(pend_q), .levels(levels), .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign code_next = found
    ? CODE_BASE + CODE_W'({{(CODE_W-IDX_W){1'b0}}, win_idx}) * CODE_STEP
    : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      irq_lvl  <= '0;
      irq_code <= '0;
    end else begin
      irq_out  <= found && (win_lvl > cpu_mask);
      irq_lvl  <= win_lvl;
      irq_code <= code_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      evt_q <= '0;
    else if (cpu_ack && irq_out)
      evt_q <= irq_code;
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NPRW; w++)
      if (bus_addr == ADDR_W'(w)) rd_next = words[w];
    if (bus_addr == ADDR_W'(FLAG_ADDR)) rd_next = DATA_W'(pend_q);
    if (bus_addr == ADDR_W'(EVT_ADDR))  rd_next = DATA_W'(evt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int               NSRC      = 12,
  parameter int               CODE_W    = 16,
  parameter logic [CODE_W-1:0] CODE_BASE = 16'h0200,
  parameter logic [CODE_W-1:0] CODE_STEP = 16'h0020
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cpu_mask,
  input logic              cpu_ack,
  input logic              irq_out,
  input logic [3:0]        irq_lvl,
  input logic [CODE_W-1:0] irq_code,
  input logic [CODE_W-1:0] evt_q,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   clr
);
  assert_mask_strict_R5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_lvl > $past(cpu_mask)));

  assert_zero_level_never_R4: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_lvl != 4'd0));

  assert_code_grid_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (irq_code >= CODE_BASE &&
                 ((irq_code - CODE_BASE) % CODE_STEP) == '0 &&
                 ((irq_code - CODE_BASE) / CODE_STEP) < CODE_W'(NSRC)));

  assert_ack_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_out) |=> (evt_q == $past(irq_code)));

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ack && irq_out) |=> $stable(evt_q));

  assert_sticky_flag_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .NSRC(NSRC), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE), .CODE_STEP(CODE_STEP)
) u_chk (
  .clk(clk), .rst(rst), .cpu_mask(cpu_mask), .cpu_ack(cpu_ack),
  .irq_out(irq_out), .irq_lvl(irq_lvl), .irq_code(irq_code),
  .evt_q(evt_q), .pend(pend_q), .clr(clr_vec)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int NSRC = 12;
  localparam int AW   = 3;
  localparam int FLAG = 2;
  localparam int EVT  = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] src_req;
  logic [3:0]      cpu_mask;
  logic            cpu_ack;
  logic            bus_we;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq_out;
  logic [3:0]      irq_lvl;
  logic [15:0]     irq_code;

  int checks = 0;
  int fails  = 0;
  logic [3:0]      m_prio [NSRC];
  logic [NSRC-1:0] m_pend;

  always #10 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst(rst), .src_req(src_req), .cpu_mask(cpu_mask), .cpu_ack(cpu_ack),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .irq_lvl(irq_lvl), .irq_code(irq_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == FLAG) m_pend = (m_pend & ~d[NSRC-1:0]) | src_req;
    if (a < 2)
      for (int j = 0; j < 8; j++)
        if (a * 8 + j < NSRC) m_prio[a * 8 + j] = d[4*j +: 4];
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_req(input logic [NSRC-1:0] r);
    @(negedge clk);
    src_req = r;
    m_pend  = m_pend | r;
  endtask

  function automatic void pick(output int idx, output logic [3:0] lvl);
    lvl = 0; idx = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_pend[i] && m_prio[i] > lvl) begin lvl = m_prio[i]; idx = i; end
  endfunction

  task automatic check_out(input string tag);
    int idx; logic [3:0] lvl;
    pick(idx, lvl);
    check({tag, " irq_lvl"}, 32'(irq_lvl), 32'(lvl));
    check({tag, " irq_code"}, 32'(irq_code), (lvl != 0) ? 32'h200 + 32'(idx) * 32'h20 : 32'h0);
    check({tag, " irq_out"}, 32'(irq_out), 32'((lvl != 0) && (lvl > cpu_mask)));
  endtask

  task automatic clear_all();
    set_req('0);
    bus_write(FLAG, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] w0, w1, evt_before;
    rst = 1'b1; src_req = '0; cpu_mask = 0; cpu_ack = 0;
    bus_we = 0; bus_addr = '0; bus_wdata = '0; m_pend = '0;
    for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
    void'($urandom(32'd20240));
    tick(4);
    rst = 1'b0;
    tick(1);

    // R6 reset state
    check("R6 irq_out", 32'(irq_out), 0);
    check("R6 irq_lvl", 32'(irq_lvl), 0);
    check("R6 irq_code", 32'(irq_code), 0);
    bus_read(EVT, rd);  check("R6 event reg", rd, 0);
    bus_read(FLAG, rd); check("R6 flags", rd, 0);
    bus_read(0, rd);    check("R6 prio word", rd, 0);

    // R10 priority word layout and readback
    bus_write(0, 32'h8765_4321);
    bus_write(1, 32'hABCD_0F1E);
    bus_read(0, rd); check("R10 word0 readback", rd, 32'h8765_4321);
    bus_read(1, rd); check("R10 word1 readback", rd, 32'hABCD_0F1E);
    set_req(12'h800); tick(2);
    check("R10 source 11 level", 32'(irq_lvl), 32'h0);
    clear_all();
    set_req(12'h200); tick(2);
    check("R10 source 9 level", 32'(irq_lvl), 32'h1);
    clear_all();

    // R3 tie goes to lowest index
    bus_write(0, 32'h5000_5000);
    bus_write(1, 32'h0000_0000);
    set_req(12'h088); tick(2);
    check_out("R3 tie");
    check("R3 tie winner code", 32'(irq_code), 32'h260);
    clear_all();

    // R4 level-0 source ignored
    bus_write(0, 32'h0010_0000);
    set_req(12'h004); tick(2);
    check("R4 only level0 irq_out", 32'(irq_out), 0);
    check("R4 only level0 irq_lvl", 32'(irq_lvl), 0);
    set_req(12'h024); tick(2);
    check("R4 level0 loses to level1", 32'(irq_code), 32'h2A0);
    clear_all();

    // R5 mask boundary
    bus_write(0, 32'h0000_0600);
    set_req(12'h004);
    cpu_mask = 4'd6; tick(2);
    check("R5 equal mask blocks", 32'(irq_out), 0);
    cpu_mask = 4'd5; tick(2);
    check("R5 lower mask passes", 32'(irq_out), 1);
    // R8 ack latches code
    @(negedge clk); cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
    bus_read(EVT, rd); check("R8 event latched", rd, 32'h240);
    cpu_mask = 4'd15; tick(2);
    bus_write(1, 32'h0000_0003);
    set_req(12'h100); tick(2);
    @(negedge clk); cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
    bus_read(EVT, rd); check("R8 ack while low ignored", rd, 32'h240);
    cpu_mask = 4'd0;
    clear_all();

    // R2 and R9 sticky flags, selective clear
    bus_write(0, 32'h0003_0090);
    bus_write(1, 32'h0);
    set_req(12'h012);
    set_req(12'h000); tick(2);
    check("R2 winner after drop", 32'(irq_code), 32'h220);
    bus_write(FLAG, 32'h0);
    bus_read(FLAG, rd); check("R9 write zero keeps flags", rd, 32'h12);
    bus_write(FLAG, 32'h2);
    bus_read(FLAG, rd); check("R9 flag readback cleared", rd, 32'h10);
    tick(1);
    check("R2 loser takes over", 32'(irq_code), 32'h280);
    check("R1 loser level", 32'(irq_lvl), 32'h3);
    clear_all();

    // R1 R5 R7 random trials
    for (int t = 0; t < 200; t++) begin
      w0 = $urandom; w1 = $urandom;
      bus_write(0, w0);
      bus_write(1, w1);
      cpu_mask = 4'($urandom);
      set_req(NSRC'($urandom));
      tick(2);
      check_out("R1 R5 R7 random");
      if (irq_out) begin
        evt_before = 32'(irq_code);
        @(negedge clk); cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
        bus_read(EVT, rd); check("R8 random ack", rd, evt_before);
      end
      clear_all();
      bus_read(FLAG, rd); check("R9 clear all", rd, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule